// File: doc/BRIEF.md
# Sampled-Clock Multi-Port Write Memory

This block is a small multi-port RAM whose write ports each have a clock of their own, built entirely on one fast global clock. No port clock drives a flip-flop. Each port clock is treated as ordinary data: it is sampled on every global cycle, and a write on that port is committed only in the global cycle where the sampled value shows the port's active edge. The write then uses the enable, address and data that were captured one global cycle earlier, not the values present in the edge cycle. This lets a design with several write clocks be modelled, or checked formally, in a single clock domain.

Each write port has a per-bit write enable as wide as the data word. A parameter sets the active edge of each port (rising or falling). A second parameter marks ports as unclocked: such a port skips the edge emulation and writes its live inputs on every global cycle where it is enabled. Read ports are purely combinational. When several ports write the same bit in one global cycle, the port with the highest index wins. A synchronous active-high reset clears the storage and sets each port's clock history to the port's inactive level.

Top module: `sclk_wr_ram`

## Requirements
- R1: Each write port keeps a one-bit sample of its port clock, refreshed from `wr_clk[p]` on every global clock cycle outside reset.
- R2: Reset sets the clock sample of a rising-edge port to 1 and of a falling-edge port to 0, so a port clock held at that level after reset causes no write, even with all enables set.
- R3: A rising-edge port commits a write in the global cycle where `wr_clk[p]` is 1 and its previous sample is 0; a falling-edge port commits where `wr_clk[p]` is 0 and its previous sample is 1.
- R4: A clocked port writes the enable, address and data it sampled one global cycle before the edge cycle; the values on its inputs in the edge cycle itself are ignored for that write.
- R5: A clocked port with no detected edge writes nothing, whatever its enables are.
- R6: Port p's enable field is `wr_en[p*DATA_W +: DATA_W]`; bit b of that field alone gates bit b of `wr_data[p*DATA_W +: DATA_W]` into bit b of the word at `wr_addr[p*ADDR_W +: ADDR_W]`.
- R7: A port whose bit in `WR_CLOCKED` is 0 ignores `wr_clk[p]` and writes its live enable, address and data on every global clock edge.
- R8: When several ports write the same bit on the same global edge, the value of the highest-indexed port is stored.
- R9: Reset clears every memory word to zero.
- R10: Read port r returns, without any clock delay, the word at `rd_addr[r*ADDR_W +: ADDR_W]`; an address at or above `DEPTH` reads as zero, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock; all storage updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_clk | input | NUM_WR | Per-port write clock, sampled as data |
| wr_en | input | NUM_WR*DATA_W | Per-port, per-bit write enables |
| wr_addr | input | NUM_WR*ADDR_W | Per-port write addresses |
| wr_data | input | NUM_WR*DATA_W | Per-port write data |
| rd_addr | input | NUM_RD*ADDR_W | Per-port read addresses |
| rd_data | output | NUM_RD*DATA_W | Per-port combinational read data |

## Verification
The bench builds the block with three write ports and two read ports, 4-bit addresses, 8-bit data and a depth of 12. Port 0 is rising-edge, port 1 falling-edge and port 2 unclocked, so both edge polarities, the bypass path and three-way write collisions are all reachable. A depth below the address range leaves addresses 12 to 15 out of range, which exercises the ignored writes and zero reads. The two read ports sweep all sixteen addresses at different strides, so every word is compared with the reference model many times.

// File: rtl/swr_pkg.sv
package swr_pkg;

  // Edge seen on a sampled clock: now vs. previous sample, for the given polarity.
  function automatic logic swr_edge_hit(input logic now_lvl, input logic prev_lvl,
                                        input logic rising);
    if (rising) return now_lvl & ~prev_lvl;
    else        return ~now_lvl & prev_lvl;
  endfunction

  // Inactive level a port clock rests at, used as the reset value of its sample.
  function automatic logic swr_rest_level(input logic rising);
    return rising;
  endfunction

endpackage

// File: rtl/swr_clk_sampler.sv
module swr_clk_sampler #(
  parameter logic RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic port_clk,
  output logic hist_q,
  output logic edge_hit
);
  import swr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= swr_rest_level(RISING);
    else     hist_q <= port_clk;
  end

  assign edge_hit = swr_edge_hit(port_clk, hist_q, RISING);

endmodule

// File: rtl/swr_wr_stage.sv
module swr_wr_stage #(
  parameter int   ADDR_W  = 4,
  parameter int   DATA_W  = 8,
  parameter logic CLOCKED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_hit,
  input  logic [DATA_W-1:0] en_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] eff_en,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] eff_data
);

  generate
    if (CLOCKED) begin : g_emulated
      logic [DATA_W-1:0] en_q;
      logic [ADDR_W-1:0] addr_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= '0;
          addr_q <= '0;
          data_q <= '0;
        end else begin
          en_q   <= en_in;
          addr_q <= addr_in;
          data_q <= data_in;
        end
      end

      assign eff_en   = edge_hit ? en_q : '0;
      assign eff_addr = addr_q;
      assign eff_data = data_q;
    end else begin : g_bypass
      logic unused_bypass;
      assign unused_bypass = ^{clk, rst, edge_hit};
      assign eff_en   = en_in;
      assign eff_addr = addr_in;
      assign eff_data = data_in;
    end
  endgenerate

endmodule

// File: rtl/swr_bit_array.sv
module swr_bit_array #(
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WR*DATA_W-1:0]   w_en,
  input  logic [NUM_WR*ADDR_W-1:0]   w_addr,
  input  logic [NUM_WR*DATA_W-1:0]   w_data,
  input  logic [NUM_RD*ADDR_W-1:0]   r_addr,
  output logic [NUM_RD*DATA_W-1:0]   r_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return 32'(a) < 32'(DEPTH);
  endfunction

  // Later ports overwrite earlier ones inside the loop: highest index wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NUM_WR; p++) begin
        if (in_range(w_addr[p*ADDR_W +: ADDR_W])) begin
          for (int b = 0; b < DATA_W; b++) begin
            if (w_en[p*DATA_W + b])
              mem[w_addr[p*ADDR_W +: ADDR_W]][b] <= w_data[p*DATA_W + b];
          end
        end
      end
    end
  end

  generate
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      logic [ADDR_W-1:0] ra;
      assign ra = r_addr[r*ADDR_W +: ADDR_W];
      assign r_data[r*DATA_W +: DATA_W] = in_range(ra) ? mem[ra] : '0;
    end
  endgenerate

endmodule

// File: rtl/sclk_wr_ram.sv
module sclk_wr_ram #(
  parameter int              NUM_WR     = 2,
  parameter int              NUM_RD     = 2,
  parameter int              ADDR_W     = 4,
  parameter int              DATA_W     = 8,
  parameter int              DEPTH      = 16,
  parameter logic [NUM_WR-1:0] WR_RISING  = '1,
  parameter logic [NUM_WR-1:0] WR_CLOCKED = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_WR-1:0]        wr_clk,
  input  logic [NUM_WR*DATA_W-1:0] wr_en,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);

  localparam int WE_W = NUM_WR * DATA_W;
  localparam int WA_W = NUM_WR * ADDR_W;

  logic [NUM_WR-1:0] hist_bus;
  logic [NUM_WR-1:0] edge_bus;
  logic [WE_W-1:0]   eff_en_bus;
  logic [WA_W-1:0]   eff_addr_bus;
  logic [WE_W-1:0]   eff_data_bus;

  generate
    for (genvar p = 0; p < NUM_WR; p++) begin : g_wport
      swr_clk_sampler #(
        .RISING (WR_RISING[p])
      ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .port_clk (wr_clk[p]),
        .hist_q   (hist_bus[p]),
        .edge_hit (edge_bus[p])
      );

      swr_wr_stage #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CLOCKED (WR_CLOCKED[p])
      ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (edge_bus[p]),
        .en_in    (wr_en[p*DATA_W +: DATA_W]),
        .addr_in  (wr_addr[p*ADDR_W +: ADDR_W]),
        .data_in  (wr_data[p*DATA_W +: DATA_W]),
        .eff_en   (eff_en_bus[p*DATA_W +: DATA_W]),
        .eff_addr (eff_addr_bus[p*ADDR_W +: ADDR_W]),
        .eff_data (eff_data_bus[p*DATA_W +: DATA_W])
      );
    end
  endgenerate

  swr_bit_array #(
    .NUM_WR (NUM_WR),
    .NUM_RD (NUM_RD),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk    (clk),
    .rst    (rst),
    .w_en   (eff_en_bus),
    .w_addr (eff_addr_bus),
    .w_data (eff_data_bus),
    .r_addr (rd_addr),
    .r_data (rd_data)
  );

endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int                NUM_WR     = 2,
  parameter int                DATA_W     = 8,
  parameter logic [NUM_WR-1:0] WR_RISING  = '1,
  parameter logic [NUM_WR-1:0] WR_CLOCKED = '1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_WR-1:0]        wr_clk,
  input logic [NUM_WR*DATA_W-1:0] wr_en,
  input logic [NUM_WR-1:0]        hist,
  input logic [NUM_WR*DATA_W-1:0] eff_en
);

  generate
    for (genvar p = 0; p < NUM_WR; p++) begin : g_port
      assert_hist_tracks_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (hist[p] == $past(wr_clk[p])));

      assert_hist_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hist[p] == WR_RISING[p]));

      if (WR_CLOCKED[p]) begin : g_clocked
        assert_write_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
          (eff_en[p*DATA_W +: DATA_W] != '0) |->
            (WR_RISING[p] ? (wr_clk[p] && !hist[p]) : (!wr_clk[p] && hist[p])));

        assert_enable_delayed_R4: assert property (@(posedge clk) disable iff (rst)
          !rst |=> ((eff_en[p*DATA_W +: DATA_W] & ~$past(wr_en[p*DATA_W +: DATA_W])) == '0));
      end else begin : g_live
        assert_bypass_live_R7: assert property (@(posedge clk) disable iff (rst)
          eff_en[p*DATA_W +: DATA_W] == wr_en[p*DATA_W +: DATA_W]);
      end
    end
  endgenerate

endmodule

bind sclk_wr_ram swr_checker #(
  .NUM_WR     (NUM_WR),
  .DATA_W     (DATA_W),
  .WR_RISING  (WR_RISING),
  .WR_CLOCKED (WR_CLOCKED)
) u_swr_checker (
  .clk    (clk),
  .rst    (rst),
  .wr_clk (wr_clk),
  .wr_en  (wr_en),
  .hist   (hist_bus),
  .eff_en (eff_en_bus)
);

// File: tb/test_sclk_wr_ram.sv
`timescale 1ns/1ps
module test_sclk_wr_ram;
  localparam int NW = 3;
  localparam int NR = 2;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 12;
  localparam logic [NW-1:0] RISE = 3'b101;
  localparam logic [NW-1:0] CLKD = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    wr_clk = '0;
  logic [NW*DW-1:0] wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  always #5 clk = ~clk;

  sclk_wr_ram #(
    .NUM_WR(NW), .NUM_RD(NR), .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH),
    .WR_RISING(RISE), .WR_CLOCKED(CLKD)
  ) i_sclk_wr_ram (
    .clk(clk), .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Behavioural reference model
  logic [DW-1:0] mdl_mem [DEPTH];
  bit            mdl_hist [NW];
  logic [DW-1:0] mdl_en [NW];
  logic [AW-1:0] mdl_addr [NW];
  logic [DW-1:0] mdl_data [NW];
  bit started = 0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_tag = "R9";
  bit done = 0;

  task automatic mdl_write(input logic [DW-1:0] e, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
    if (int'(a) < DEPTH)
      for (int b = 0; b < DW; b++)
        if (e[b]) mdl_mem[a][b] = d[b];
  endtask

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
      for (int p = 0; p < NW; p++) begin
        mdl_hist[p] = RISE[p];
        mdl_en[p] = '0; mdl_addr[p] = '0; mdl_data[p] = '0;
      end
    end else begin
      for (int p = 0; p < NW; p++) begin
        if (CLKD[p]) begin
          bit seen;
          seen = RISE[p] ? (wr_clk[p] && !mdl_hist[p]) : (!wr_clk[p] && mdl_hist[p]);
          if (seen) mdl_write(mdl_en[p], mdl_addr[p], mdl_data[p]);
        end else begin
          mdl_write(wr_en[p*DW +: DW], wr_addr[p*AW +: AW], wr_data[p*DW +: DW]);
        end
      end
      for (int p = 0; p < NW; p++) begin
        mdl_hist[p] = wr_clk[p];
        mdl_en[p]   = wr_en[p*DW +: DW];
        mdl_addr[p] = wr_addr[p*AW +: AW];
        mdl_data[p] = wr_data[p*DW +: DW];
      end
    end
  end

  // Compare both read ports every cycle, then move the read addresses (R10).
  always @(negedge clk) begin
    if (started && !done) begin
      for (int r = 0; r < NR; r++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] exp_v;
        a = rd_addr[r*AW +: AW];
        exp_v = (int'(a) < DEPTH) ? mdl_mem[a] : '0;
        n_cmp++;
        if (rd_data[r*DW +: DW] !== exp_v) begin
          n_bad++;
          $display("FAIL %s: read port %0d addr %0d actual %h expected %h (cycle %0d)",
                   cur_tag, r, a, rd_data[r*DW +: DW], exp_v, cyc);
        end
      end
      rd_addr[0 +: AW]  = AW'(cyc % 16);
      rd_addr[AW +: AW] = AW'((cyc * 7 + 3) % 16);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_port(input int p, input logic c, input logic [DW-1:0] e,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_clk[p] = c;
    wr_en[p*DW +: DW] = e;
    wr_addr[p*AW +: AW] = a;
    wr_data[p*DW +: DW] = d;
  endtask

  // Sweep reads long enough to visit every address.
  task automatic settle();
    set_port(2, 1'b0, 8'h00, 4'd0, 8'h00);
    tick(20);
  endtask

  initial begin
    // R9: contents zero after reset
    cur_tag = "R9";
    set_port(0, 1'b1, 8'h00, 0, 0);
    set_port(1, 1'b0, 8'h00, 0, 0);
    set_port(2, 1'b0, 8'h00, 0, 0);
    tick(3);
    rst = 1'b0;
    tick(17);

    // R2: clocks at rest level after reset, all enables set: no write
    cur_tag = "R2";
    rst = 1'b1;
    set_port(0, 1'b1, 8'hff, 4'd1, 8'hff);
    set_port(1, 1'b0, 8'hff, 4'd2, 8'hff);
    tick(2);
    rst = 1'b0;
    tick(20);

    // R3: rising edge on port 0, falling edge on port 1
    cur_tag = "R3";
    set_port(0, 1'b0, 8'hff, 4'd1, 8'ha5); tick(1);
    set_port(0, 1'b1, 8'hff, 4'd1, 8'ha5); tick(1);
    set_port(1, 1'b1, 8'hff, 4'd2, 8'h5a); tick(1);
    set_port(1, 1'b0, 8'hff, 4'd2, 8'h5a); tick(1);
    settle();

    // R4: live values in the edge cycle are ignored
    cur_tag = "R4";
    set_port(0, 1'b0, 8'hff, 4'd3, 8'h3c); tick(1);
    set_port(0, 1'b1, 8'hff, 4'd4, 8'hc3); tick(1);
    set_port(0, 1'b1, 8'h00, 4'd4, 8'h00); tick(1);
    settle();

    // R5: wrong-direction transitions and held clocks write nothing
    cur_tag = "R5";
    set_port(0, 1'b1, 8'hff, 4'd5, 8'h77); tick(1);
    set_port(0, 1'b0, 8'hff, 4'd5, 8'h77); tick(2);
    set_port(1, 1'b0, 8'hff, 4'd6, 8'h88); tick(1);
    set_port(1, 1'b1, 8'hff, 4'd6, 8'h88); tick(2);
    settle();

    // R6: partial per-bit enable
    cur_tag = "R6";
    set_port(0, 1'b0, 8'h0f, 4'd1, 8'h00); tick(1);
    set_port(0, 1'b1, 8'h0f, 4'd1, 8'h00); tick(1);
    set_port(1, 1'b1, 8'hf0, 4'd2, 8'hff); tick(1);
    set_port(1, 1'b0, 8'hf0, 4'd2, 8'hff); tick(1);
    settle();

    // R7: unclocked port writes live, clock ignored
    cur_tag = "R7";
    set_port(2, 1'b1, 8'hff, 4'd7, 8'h99); tick(1);
    set_port(2, 1'b0, 8'h3c, 4'd8, 8'hff); tick(1);
    set_port(2, 1'b1, 8'h00, 4'd9, 8'hff); tick(1);
    settle();

    // R8: all three ports hit address 10 on the same global edge
    cur_tag = "R8";
    set_port(0, 1'b0, 8'hff, 4'd10, 8'h11);
    set_port(1, 1'b1, 8'hff, 4'd10, 8'h22);
    tick(1);
    set_port(0, 1'b1, 8'hff, 4'd10, 8'h11);
    set_port(1, 1'b0, 8'hff, 4'd10, 8'h22);
    set_port(2, 1'b0, 8'h0f, 4'd10, 8'h33);
    tick(1);
    settle();
    set_port(0, 1'b0, 8'hff, 4'd11, 8'h44);
    set_port(1, 1'b1, 8'hf0, 4'd11, 8'h55);
    tick(1);
    set_port(0, 1'b1, 8'hff, 4'd11, 8'h44);
    set_port(1, 1'b0, 8'hf0, 4'd11, 8'h55);
    tick(1);
    settle();

    // R10: writes above DEPTH are dropped, reads there give zero
    cur_tag = "R10";
    set_port(2, 1'b0, 8'hff, 4'd13, 8'hee); tick(1);
    set_port(0, 1'b0, 8'hff, 4'd12, 8'hdd); tick(1);
    set_port(0, 1'b1, 8'hff, 4'd12, 8'hdd); tick(1);
    settle();

    // R1: random clocks, enables, addresses and data on all ports
    cur_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      wr_clk  = NW'($urandom);
      wr_en   = {$urandom, $urandom};
      wr_addr = (NW*AW)'($urandom);
      wr_data = {$urandom, $urandom};
      tick(1);
    end

    // R9: reset in the middle of activity clears everything
    cur_tag = "R9";
    rst = 1'b1;
    tick(2);
    set_port(0, 1'b1, 8'h00, 0, 0);
    set_port(1, 1'b0, 8'h00, 0, 0);
    set_port(2, 1'b0, 8'h00, 0, 0);
    rst = 1'b0;
    tick(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule